// File: doc/BRIEF.md
# Segmented Approximate Adder

This block adds two unsigned operands of `ADD_W` bits without a full-length carry chain. The operand width is cut into `SEG_N` slices of equal width. For each slice, a carry generator looks only at that slice's own operand bits and reports whether the slice would overflow with nothing coming in. Separately, a sum generator adds the slice's operand bits together with the carry generator output of the slice just below it.

A carry can therefore move across at most one slice boundary. The longest path is one slice-wide lookahead carry followed by one slice-wide sum. The result is exact whenever no carry needs to travel further than that, and approximate otherwise. The block is purely combinational. It suits datapaths that can tolerate small arithmetic errors in exchange for shorter logic depth, such as approximate bit-counting trees.

Top module: `apx_seg_adder`

## Requirements
- R1: `ADD_W` must divide evenly into `SEG_N` slices, and `SEG_N` must be at least 2. Any other parameter set stops elaboration.
- R2: The carry generator of each slice equals the carry out of adding that slice's operand bits alone, with a carry-in of zero.
- R3: Each slice of `sum_o` equals (slice of `a_i` + slice of `b_i` + carry generator output of the next lower slice), taken modulo 2^slice-width.
- R4: The least significant slice uses a carry-in of zero, so its part of `sum_o` is the plain slice sum modulo 2^slice-width.
- R5: A carry never reaches past one boundary. With ADD_W=8 and SEG_N=4, 0x0F + 0x01 gives `sum_o`=0x00 and `cout_o`=0, not the exact 0x10.
- R6: `cout_o` is the carry generator output of the most significant slice. With ADD_W=8 and SEG_N=4, 0xC0 + 0x40 gives `sum_o`=0x00 and `cout_o`=1.
- R7: With ADD_W=8 and SEG_N=4, 0xCD + 0x36 gives `sum_o`=0xC3 (195) and `cout_o`=0, where exact addition would give 259.
- R8: When no carry has to cross more than one slice boundary, {`cout_o`,`sum_o`} equals the exact sum. Examples: 0x12+0x21=0x33, 0x03+0x01=0x04, 0x44+0x44=0x88.
- R9: For random operands, {`cout_o`,`sum_o`} matches a bit-accurate model of the slice rule for every tested (ADD_W, SEG_N) pair: (8,4), (16,4), (32,8), (12,3) and (8,8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | ADD_W | First addend |
| b_i | input | ADD_W | Second addend |
| sum_o | output | ADD_W | Approximate sum, one slice at a time |
| cout_o | output | 1 | Standalone carry of the top slice |

## Verification
The assertions sit beside the slice logic. They assume only that the operands are settled two-state values when sampled. Since the block holds no state, this one input condition is all they depend on.

The bench keeps inside that condition by changing the operands on one clock edge and reading the outputs half a period later. Operands are masked to each instance's width. Directed values target the boundary where a carry is dropped, and random values cover the rest of the operand space.

// File: rtl/apx_seg_pkg.sv
package apx_seg_pkg;

   localparam int unsigned APX_MIN_SEGS = 2;

   // lowest bit index of slice idx for slices of width w
   function automatic int unsigned seg_base(input int unsigned idx, input int unsigned w);
      return idx * w;
   endfunction

endpackage

// File: rtl/apx_seg_cgen.sv
// Standalone slice carry generator: carry out of a+b with no carry in.
module apx_seg_cgen #(
   parameter int unsigned SEG_W = 2
) (
   input  logic [SEG_W-1:0] a_i,
   input  logic [SEG_W-1:0] b_i,
   output logic             cout_o
);

   generate
      if (SEG_W == 1) begin : g_single
         assign cout_o = a_i[0] & b_i[0];
      end else begin : g_lookahead
         logic [SEG_W-1:0] gen_w;
         logic [SEG_W-1:0] prop_w;
         logic [SEG_W-1:0] grp_g;
         assign gen_w  = a_i & b_i;
         assign prop_w = a_i | b_i;
         assign grp_g[0] = gen_w[0];
         for (genvar k = 1; k < SEG_W; k++) begin : g_grp
            assign grp_g[k] = gen_w[k] | (prop_w[k] & grp_g[k-1]);
         end
         assign cout_o = grp_g[SEG_W-1];
      end
   endgenerate

endmodule

// File: rtl/apx_seg_sgen.sv
// Slice sum generator: slice sum with an external carry in, carry out dropped.
module apx_seg_sgen #(
   parameter int unsigned SEG_W = 2
) (
   input  logic [SEG_W-1:0] a_i,
   input  logic [SEG_W-1:0] b_i,
   input  logic             cin_i,
   output logic [SEG_W-1:0] sum_o
);

   logic [SEG_W:0] rip_c;
   assign rip_c[0] = cin_i;

   for (genvar k = 0; k < SEG_W; k++) begin : g_bit
      assign sum_o[k]   = a_i[k] ^ b_i[k] ^ rip_c[k];
      assign rip_c[k+1] = (a_i[k] & b_i[k]) | (rip_c[k] & (a_i[k] ^ b_i[k]));
   end

   // carry leaving this slice is intentionally unused
   logic unused_top;
   assign unused_top = rip_c[SEG_W];

endmodule

// File: rtl/apx_seg_adder.sv
module apx_seg_adder
   import apx_seg_pkg::*;
#(
   parameter int unsigned ADD_W = 8,
   parameter int unsigned SEG_N = 4
) (
   input  logic [ADD_W-1:0] a_i,
   input  logic [ADD_W-1:0] b_i,
   output logic [ADD_W-1:0] sum_o,
   output logic             cout_o
);

   localparam int unsigned SEG_W = ADD_W / SEG_N;

   // R1: elaboration-time parameter checks
   generate
      if (SEG_N < APX_MIN_SEGS) begin : g_bad_segs
         $error("apx_seg_adder: SEG_N must be at least 2");
      end
      if ((ADD_W % SEG_N) != 0) begin : g_bad_split
         $error("apx_seg_adder: ADD_W must be a multiple of SEG_N");
      end
   endgenerate

   logic [SEG_N-1:0] seg_cy;
   logic [SEG_N-1:0] seg_cin;

   for (genvar s = 0; s < SEG_N; s++) begin : g_seg
      localparam int unsigned Base = seg_base(s, SEG_W);

      apx_seg_cgen #(.SEG_W(SEG_W)) cgen_i (
         .a_i    (a_i[Base +: SEG_W]),
         .b_i    (b_i[Base +: SEG_W]),
         .cout_o (seg_cy[s])
      );

      if (s == 0) begin : g_low
         assign seg_cin[s] = 1'b0;
      end else begin : g_up
         assign seg_cin[s] = seg_cy[s-1];
      end

      apx_seg_sgen #(.SEG_W(SEG_W)) sgen_i (
         .a_i   (a_i[Base +: SEG_W]),
         .b_i   (b_i[Base +: SEG_W]),
         .cin_i (seg_cin[s]),
         .sum_o (sum_o[Base +: SEG_W])
      );

      // ---- assertions for this slice ----
      logic [SEG_W:0] chk_full;
      assign chk_full = {1'b0, a_i[Base +: SEG_W]} + {1'b0, b_i[Base +: SEG_W]};

      always_comb begin
         p_seg_carry_r2: assert (seg_cy[s] == chk_full[SEG_W])
            else $error("slice carry differs from standalone slice carry");
         p_seg_sum_r3: assert (sum_o[Base +: SEG_W] ==
                               SEG_W'(chk_full[SEG_W-1:0] + SEG_W'(seg_cin[s])))
            else $error("slice sum differs from operand sum plus lower carry");
      end

      if (s == 0) begin : g_chk_low
         always_comb begin
            p_low_cin_r4: assert (sum_o[Base +: SEG_W] == chk_full[SEG_W-1:0])
               else $error("lowest slice saw a nonzero carry in");
         end
      end else begin : g_chk_up
         logic [SEG_W:0] chk_prev;
         assign chk_prev = {1'b0, a_i[Base-SEG_W +: SEG_W]} + {1'b0, b_i[Base-SEG_W +: SEG_W]};
         always_comb begin
            p_no_far_carry_r5: assert (chk_prev[SEG_W] ||
                                       (sum_o[Base +: SEG_W] == chk_full[SEG_W-1:0]))
               else $error("carry reached a slice from beyond its neighbour");
         end
      end
   end

   assign cout_o = seg_cy[SEG_N-1];

   logic [SEG_W:0] chk_top;
   assign chk_top = {1'b0, a_i[ADD_W-1 -: SEG_W]} + {1'b0, b_i[ADD_W-1 -: SEG_W]};

   always_comb begin
      p_top_cout_r6: assert (cout_o == chk_top[SEG_W])
         else $error("carry out is not the top slice standalone carry");
   end

endmodule

// File: tb/apx_seg_adder_tb_top.sv
module apx_seg_adder_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;

   logic [7:0]  s0; logic c0;
   logic [15:0] s1; logic c1;
   logic [31:0] s2; logic c2;
   logic [11:0] s3; logic c3;
   logic [7:0]  s4; logic c4;

   apx_seg_adder #(.ADD_W(8),  .SEG_N(4)) dut_i
      (.a_i(op_a[7:0]),  .b_i(op_b[7:0]),  .sum_o(s0), .cout_o(c0));
   apx_seg_adder #(.ADD_W(16), .SEG_N(4)) dut_i_w16
      (.a_i(op_a[15:0]), .b_i(op_b[15:0]), .sum_o(s1), .cout_o(c1));
   apx_seg_adder #(.ADD_W(32), .SEG_N(8)) dut_i_w32
      (.a_i(op_a),       .b_i(op_b),       .sum_o(s2), .cout_o(c2));
   apx_seg_adder #(.ADD_W(12), .SEG_N(3)) dut_i_w12
      (.a_i(op_a[11:0]), .b_i(op_b[11:0]), .sum_o(s3), .cout_o(c3));
   apx_seg_adder #(.ADD_W(8),  .SEG_N(8)) dut_i_bit
      (.a_i(op_a[7:0]),  .b_i(op_b[7:0]),  .sum_o(s4), .cout_o(c4));

   typedef struct {
      int          cfg;
      logic [32:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_run  = 0;
   int n_fail = 0;

   int cfg_w [5] = '{8, 16, 32, 12, 8};
   int cfg_n [5] = '{4, 4, 8, 3, 8};

   // bit-accurate model of the slice rule
   function automatic logic [32:0] seg_model(int n, int m, logic [31:0] a, logic [31:0] b);
      int w = n / m;
      logic [32:0] res = '0;
      logic cin = 1'b0;
      for (int s = 0; s < m; s++) begin
         logic [32:0] msk = (33'd1 << w) - 33'd1;
         logic [32:0] as_ = ({1'b0, a} >> (s * w)) & msk;
         logic [32:0] bs_ = ({1'b0, b} >> (s * w)) & msk;
         logic [32:0] raw = as_ + bs_;
         res = res | (((raw + {32'd0, cin}) & msk) << (s * w));
         cin = raw[w];
      end
      res[n] = cin;
      return res;
   endfunction

   function automatic logic [31:0] mask_to(int n, logic [31:0] v);
      return (n == 32) ? v : (v & ((32'd1 << n) - 32'd1));
   endfunction

   // driver: apply operands, push expected values for every instance
   task automatic push_all(logic [31:0] a, logic [31:0] b, string tag);
      @(posedge clk);
      op_a <= a;
      op_b <= b;
      for (int c = 0; c < 5; c++) begin
         sb_item_t it;
         it.cfg = c;
         it.exp = seg_model(cfg_w[c], cfg_n[c], mask_to(cfg_w[c], a), mask_to(cfg_w[c], b));
         it.tag = tag;
         sb_q.push_back(it);
      end
   endtask

   // driver: directed expectation for the 8-bit, 4-slice instance
   task automatic push_one(logic [7:0] a, logic [7:0] b, logic [8:0] exp, string tag);
      sb_item_t it;
      @(posedge clk);
      op_a <= {24'd0, a};
      op_b <= {24'd0, b};
      it.cfg = 0;
      it.exp = {24'd0, exp};
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compare mid-cycle
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         sb_item_t it;
         logic [32:0] act;
         it = sb_q.pop_front();
         case (it.cfg)
            0: act = {24'd0, c0, s0};
            1: act = {16'd0, c1, s1};
            2: act = {c2, s2};
            3: act = {20'd0, c3, s3};
            default: act = {24'd0, c4, s4};
         endcase
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s cfg%0d actual=%h expected=%h", it.tag, it.cfg, act, it.exp);
         end
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 100000) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // zero operands after reset (R3, R4)
      push_one(8'h00, 8'h00, 9'h000, "R3");
      push_all(32'h0, 32'h0, "R3");
      // R7 worked example
      push_one(8'hCD, 8'h36, 9'h0C3, "R7");
      // R5 carry dropped beyond one boundary
      push_one(8'h0F, 8'h01, 9'h000, "R5");
      // R6 top slice carry drives cout
      push_one(8'hC0, 8'h40, 9'h100, "R6");
      // R4 lowest slice has no carry in
      push_one(8'h02, 8'h01, 9'h003, "R4");
      // R2 carry of a slice depends only on its own bits
      push_one(8'h0C, 8'h04, 9'h010, "R2");
      // R8 exact-match cases
      push_one(8'h12, 8'h21, 9'h033, "R8");
      push_one(8'h03, 8'h01, 9'h004, "R8");
      push_one(8'h44, 8'h44, 9'h088, "R8");
      // R9 random operands against the model
      for (int i = 0; i < 300; i++) begin
         push_all($urandom(), $urandom(), "R9");
      end
      push_all(32'hFFFF_FFFF, 32'h0000_0001, "R9");
      push_all(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
      @(posedge clk);
      @(posedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule